// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address stream for a single read or write burst of a four-bank synchronous DRAM with a 10-bit column. A read or write command loads a start column, an already-decoded burst-length code and a burst type (sequential or interleave). From the next cycle on, the block presents one column address per clock, together with a valid flag. A last-beat flag marks the final address of every fixed-length burst.

A new command on any cycle abandons the current burst and starts over from its own start column. A stop request ends a burst at once. Full-page bursts never end by themselves. Interleave ordering combined with full page is not a legal setting: the block raises an error flag for it and runs a sequential full-page burst.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `col_valid`, `last_beat`, `mode_err` and `col_addr` are all 0.
- R2: A command (`cmd_go`=1) is sampled on a rising edge. After that edge, `col_valid` is 1 and `col_addr` equals the sampled `start_col` (beat 0). Each following edge advances the beat index i by one.
- R3: Sequential fixed burst of length N (`btype`=0): beat i outputs start_col with its low log2(N) bits replaced by (start_col + i) mod N. The address wraps inside the aligned N-word block.
- R4: Interleave burst (`btype`=1, fixed length N): beat i outputs start_col XOR i, so only the low log2(N) bits change.
- R5: `blen_sel` codes 0, 1, 2 and 3 select N = 1, 2, 4 and 8. Codes 4 to 7 select full page. A fixed burst keeps `col_valid` high for exactly N cycles and then drops it.
- R6: `last_beat` is high exactly on beat N-1 of a fixed burst. It is never high in full-page mode.
- R7: Full page: beat i outputs (start_col + i) mod 1024. The burst keeps running past column 1023 until a stop or a new command.
- R8: `stop_req`=1 without `cmd_go` ends a burst: `col_valid` and `last_beat` are 0 after that edge.
- R9: A command during a burst restarts it from the new start column and settings. When `cmd_go` and `stop_req` are high together, the command wins.
- R10: A command with `btype`=1 and a full-page code sets `mode_err` from the next cycle until the next command, and the burst is addressed as sequential full page. Every legal command clears `mode_err`.
- R11: `stop_req` while idle has no effect: the outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Read or write command: load settings and start a burst |
| start_col | input | 10 | Start column sampled with the command |
| blen_sel | input | 3 | Burst length code: 0..3 give 1/2/4/8, 4..7 give full page |
| btype | input | 1 | Burst type: 0 sequential, 1 interleave |
| stop_req | input | 1 | Burst terminate request |
| col_addr | output | 10 | Column address of the current beat, 0 when idle |
| col_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat is the last of a fixed-length burst |
| mode_err | output | 1 | Last command asked for interleave with full page |

## Verification
Every result of this block is due one rising edge after the inputs that cause it. The beat-0 address and the error flag appear after the command edge, and each later beat appears one edge later. A stop or a restart takes effect after the edge that samples it. The driver applies inputs at the falling edge and pushes the expected outputs for the next rising edge into a queue. The monitor pops and compares them 2 ns after that rising edge, so each comparison lines up with exactly one register stage.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic {
    BT_SEQ = 1'b0,
    BT_ILV = 1'b1
  } burst_type_e;
endpackage

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int BL_W    = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_go,
  input  logic [COL_W-1:0] start_col,
  input  logic [BL_W-1:0]  blen_sel,
  input  logic             btype,
  input  logic             stop_req,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             full_q,
  output logic             last,
  output logic             err_q
);
  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ONE      = COL_W'(1);

  logic             full_d;
  logic [COL_W-1:0] mask_d;

  always_comb begin
    full_d = (int'(blen_sel) > MAX_LOG);
    mask_d = full_d ? ALL_ONES : ((ONE << blen_sel) - ONE);
  end

  assign last = active && !full_q && (idx == mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      start_q <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (cmd_go) begin
      active  <= 1'b1;
      idx     <= '0;
      start_q <= start_col;
      mask_q  <= mask_d;
      full_q  <= full_d;
      ilv_q   <= (btype == BT_ILV) && !full_d;
      err_q   <= (btype == BT_ILV) && full_d;
    end else if (stop_req) begin
      active <= 1'b0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + ONE;
    end
  end

  // R2: a command starts beat 0 at the sampled column
  a_r2_cmd_starts: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (active && idx == '0 && start_q == $past(start_col)));
  // R5: a fixed burst ends after its final beat
  a_r5_last_ends: assert property (@(posedge clk) disable iff (rst)
    (last && !cmd_go && !stop_req) |=> !active);
  // R6: no last beat in full page
  a_r6_no_last_full: assert property (@(posedge clk) disable iff (rst)
    full_q |-> !last);
  // R8: stop without command ends the burst
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !cmd_go) |=> !active);
  // R10: error flag follows the illegal combination
  a_r10_err_flag: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (err_q == ($past(btype) && full_q)));
  // R11: idle stays idle without a command
  a_r11_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!active && !cmd_go) |=> !active);
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] start_q,
  input  logic [COL_W-1:0] mask_q,
  input  logic             ilv_q,
  input  logic             full_q,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] seq_addr;
  logic [COL_W-1:0] ilv_addr;
  logic [COL_W-1:0] sum;

  always_comb begin
    sum      = start_q + idx;
    seq_addr = (start_q & ~mask_q) | (sum & mask_q);
    ilv_addr = start_q ^ idx;
    if (!active)    addr = '0;
    else if (ilv_q) addr = ilv_addr;
    else            addr = seq_addr;
  end

  // R4: interleave touches only the low bits
  a_r4_ilv_high: assert property (@(posedge clk) disable iff (rst)
    (active && ilv_q) |-> (addr[COL_W-1:MAX_LOG] == start_q[COL_W-1:MAX_LOG]));
  // R3: sequential fixed burst stays inside its aligned block
  a_r3_seq_block: assert property (@(posedge clk) disable iff (rst)
    (active && !ilv_q && !full_q) |-> ((addr & ~mask_q) == (start_q & ~mask_q)));
  // R7: full page steps by one modulo the column space
  a_r7_full_step: assert property (@(posedge clk) disable iff (rst)
    (active && full_q && idx != '0) |-> (addr == start_q + idx));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int BL_W    = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_go,
  input  logic [COL_W-1:0] start_col,
  input  logic [BL_W-1:0]  blen_sel,
  input  logic             btype,
  input  logic             stop_req,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             last_beat,
  output logic             mode_err
);
  logic             active;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             full_q;
  logic             last;
  logic             err_q;

  colgen_seq #(.COL_W(COL_W), .BL_W(BL_W), .MAX_LOG(MAX_LOG)) u_seq (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .start_col(start_col),
    .blen_sel(blen_sel), .btype(btype), .stop_req(stop_req),
    .active(active), .idx(idx), .start_q(start_q), .mask_q(mask_q),
    .ilv_q(ilv_q), .full_q(full_q), .last(last), .err_q(err_q)
  );

  colgen_addr #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_addr (
    .clk(clk), .rst(rst), .active(active), .idx(idx), .start_q(start_q),
    .mask_q(mask_q), .ilv_q(ilv_q), .full_q(full_q), .addr(col_addr)
  );

  assign col_valid = active;
  assign last_beat = last;
  assign mode_err  = err_q;

  // R9: a command has priority over a stop
  a_r9_cmd_wins: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && stop_req) |=> col_valid);
  // R1: nothing is presented without a burst
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !col_valid |-> (col_addr == '0 && !last_beat));
endmodule

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_go = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] blen_sel = '0;
  logic       btype = 1'b0;
  logic       stop_req = 1'b0;
  logic [9:0] col_addr;
  logic       col_valid, last_beat, mode_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] q_exp[$];
  string       q_tag[$];

  // reference state after the next edge
  bit m_act = 0, m_full = 0, m_ilv = 0, m_err = 0;
  int m_st = 0, m_n = 1, m_i = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen uut (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .start_col(start_col),
    .blen_sel(blen_sel), .btype(btype), .stop_req(stop_req),
    .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat),
    .mode_err(mode_err)
  );

  function automatic logic [9:0] ref_addr(int st, int n, bit ilv, int i);
    int base;
    if (ilv) return 10'(st ^ i);
    base = st - (st % n);
    return 10'(base + ((st % n) + i) % n);
  endfunction

  task automatic tick(bit cmd, int st, int sel, bit mode, bit stp, string tag);
    logic [9:0] ea;
    bit el;
    @(negedge clk);
    cmd_go = cmd; start_col = 10'(st); blen_sel = 3'(sel);
    btype = mode; stop_req = stp;
    if (cmd) begin
      m_act = 1; m_i = 0; m_st = st;
      m_full = (sel >= 4);
      m_n = m_full ? 1024 : (1 << sel);
      m_ilv = mode && !m_full;
      m_err = mode && m_full;
    end else if (stp) begin
      m_act = 0;
    end else if (m_act) begin
      if (!m_full && m_i == m_n - 1) m_act = 0;
      else m_i = (m_i + 1) % 1024;
    end
    ea = m_act ? ref_addr(m_st, m_n, m_ilv, m_i) : 10'd0;
    el = m_act && !m_full && (m_i == m_n - 1);
    q_exp.push_back({m_err, el, m_act, ea});
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, tag);
  endtask

  // monitor
  initial begin
    logic [12:0] e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if ({mode_err, last_beat, col_valid, col_addr} !== e) begin
          errors++;
          $display("FAIL %s: got err=%0b last=%0b valid=%0b addr=%h expected err=%0b last=%0b valid=%0b addr=%h",
                   t, mode_err, last_beat, col_valid, col_addr, e[12], e[11], e[10], e[9:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({mode_err, last_beat, col_valid, col_addr} !== 13'd0) begin
      errors++;
      $display("FAIL R1: got %h expected 0", {mode_err, last_beat, col_valid, col_addr});
    end
    @(negedge clk); rst = 1'b0;
    idle(1, "R1 after reset");
    // R3/R5: sequential length 4, wrap inside block
    tick(1, 10'h0B6, 2, 0, 0, "R2 seq4 beat0");
    idle(5, "R3 seq4 wrap, R6 last");
    // R3/R5: sequential length 8 near top of column space
    tick(1, 10'h3FD, 3, 0, 0, "R2 seq8 beat0");
    idle(9, "R3 seq8 wrap, R5 length");
    // R5/R6: length 1 and 2
    tick(1, 5, 0, 0, 0, "R5 len1 last");
    idle(2, "R5 len1 end");
    tick(1, 10'h011, 1, 0, 0, "R5 seq2 beat0");
    idle(3, "R3 seq2 wrap");
    // R4: interleave 8 and 4
    tick(1, 10'h02D, 3, 1, 0, "R4 ilv8 beat0");
    idle(9, "R4 ilv8 order");
    tick(1, 10'h01E, 2, 1, 0, "R4 ilv4 beat0");
    idle(5, "R4 ilv4 order");
    // R7/R8: full page across column 1023 then stop
    tick(1, 10'h3FC, 7, 0, 0, "R7 full beat0");
    idle(8, "R7 full wrap, R6 no last");
    tick(0, 0, 0, 0, 1, "R8 stop");
    idle(2, "R8 stays idle");
    // R11: stop while idle
    tick(0, 0, 0, 0, 1, "R11 stop idle");
    tick(0, 0, 0, 0, 1, "R11 stop idle");
    // R9: restart mid-burst
    tick(1, 10'h100, 3, 0, 0, "R9 first burst");
    idle(3, "R9 first burst");
    tick(1, 10'h203, 2, 0, 0, "R9 restart");
    idle(5, "R9 restarted burst");
    // R9: command and stop together
    tick(1, 10'h040, 2, 1, 0, "R9 burst");
    idle(1, "R9 burst");
    tick(1, 10'h077, 1, 0, 1, "R9 cmd beats stop");
    idle(3, "R9 after priority");
    // R8: stop on a fixed burst
    tick(1, 10'h0A0, 3, 0, 0, "R8 fixed");
    idle(2, "R8 fixed");
    tick(0, 0, 0, 0, 1, "R8 fixed stop");
    idle(1, "R8 fixed idle");
    // R10: interleave with full page
    tick(1, 10'h3FE, 7, 1, 0, "R10 illegal beat0");
    idle(4, "R10 seq full wrap");
    tick(0, 0, 0, 0, 1, "R10 err held after stop");
    idle(1, "R10 err held");
    tick(1, 10'h123, 5, 1, 0, "R10 illegal code5");
    idle(2, "R10 code5");
    tick(1, 10'h008, 2, 0, 0, "R10 legal clears");
    idle(5, "R10 cleared");
    // R5: full page with code 4, restarted by commands every cycle
    tick(1, 10'h3FF, 4, 0, 0, "R5 code4 full");
    idle(3, "R7 code4 wrap");
    for (int k = 0; k < 4; k++) tick(1, 10'h050 + k, 0, k[0], 0, "R9 back-to-back len1");
    idle(2, "R5 len1 end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule